// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block sits beside a bank of eighteen counter/timer channels, arranged as three groups of two counter units with three channels each. For every channel it keeps one clock-source selection and one gate-source selection. It drives one clock output and one gate output per channel from those selections. A host changes a selection by writing a single byte to a group's clock-select or gate-select address. That byte names the counter unit, the channel within the unit and a source number.

The internal clock rates come from a 40 MHz base clock through cascaded counters. They are produced as single-cycle enable pulses, so the block creates no derived clock nets. Setting the enhanced-mode input widens the source number from three bits to five and unlocks the 20 MHz source. A source number with no function assigned to it drives a constant 0.

Top module: `ctr_src_router`

## Requirements
- R1: A write to address 0x18+g (g = 0..2) updates a clock selection in group g. A write to 0x1B+g updates a gate selection in group g. A write to any other address changes no selection.
- R2: In the write byte, bit 5 selects the counter unit and bits 4:3 select the channel, which must be 0..2. Together they address output channel 6·g + 3·unit + channel. A channel field of 3 makes the write change nothing.
- R3: The source number is formed from bits 7:6 as source bits 4:3 and bits 2:0 as source bits 2:0. While `enh_mode` is 0, bits 7:6 are treated as zero.
- R4: Clock source 0 passes the channel's `ext_clk` bit to its output. Gate source 0 holds the gate output at 1. Gate source 1 passes the channel's `ext_gate` bit to its output. Every output is registered, so it shows its input one clock later.
- R5: Clock sources 1 to 5 give single-cycle pulses every 4, 40, 400, 4000 and 40000 base-clock cycles. At 40 MHz these are 10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz.
- R6: Clock source 11 pulses every 2 cycles (20 MHz) while `enh_mode` is 1. It drives 0 while `enh_mode` is 0.
- R7: Any clock source from 6 to 31 other than 11, and any gate source from 2 to 31, drives a constant 0.
- R8: Reset returns every channel to clock source 0 and gate source 0. While reset is held, every gate output is 1 and every clock output is 0.
- R9: A write changes only the one selection it addresses. All other channels, and the other selection of the same channel, keep their settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enh_mode | input | 1 | Enables 5-bit source numbers and the 20 MHz source |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host byte address |
| wr_data | input | 8 | Packed unit, channel and source byte |
| ext_clk | input | 18 | Dedicated external clock per channel |
| ext_gate | input | 18 | External gate input per channel |
| clk_out | output | 18 | Routed clock (or clock enable) per channel |
| gate_out | output | 18 | Routed gate per channel |

## Verification
The bench checks every output after each write. A decoder that swapped the unit and channel fields, or took the wrong group offset, would move a selection onto a neighbouring channel, and this check catches it. Writes with high source bits in normal mode are included. A design that kept those bits would turn a legal source into a reserved one that reads 0. A write with channel field 3 is included too, because a design that wrapped it would overwrite a real channel. Pulse intervals are measured on all six rates. This catches an off-by-one divider, and a 20 MHz source that keeps running after enhanced mode is turned off.

// File: rtl/ctr_src_router.sv
module ctr_src_router #(
  parameter int N_GRP     = 3,
  parameter int N_UNIT    = 2,
  parameter int N_CH      = 3,
  parameter int SRC_W     = 5,
  parameter int ADDR_W    = 8,
  parameter int CLK_BASE  = 'h18,
  parameter int GATE_BASE = 'h1B,
  parameter int PRE_DIV   = 4,
  parameter int DEC_DIV   = 10,
  parameter int N_DEC     = 4,
  parameter int FAST_SRC  = 11
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                enh_mode,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [7:0]                          wr_data,
  input  logic [N_GRP*N_UNIT*N_CH-1:0]        ext_clk,
  input  logic [N_GRP*N_UNIT*N_CH-1:0]        ext_gate,
  output logic [N_GRP*N_UNIT*N_CH-1:0]        clk_out,
  output logic [N_GRP*N_UNIT*N_CH-1:0]        gate_out
);
  localparam int NCHAN  = N_GRP * N_UNIT * N_CH;
  localparam int PW     = $clog2(PRE_DIV);
  localparam int DW     = $clog2(DEC_DIV);
  localparam int N_RATE = N_DEC + 1;

  logic [PW-1:0]       pre_q;
  logic                half_q;
  logic [DW-1:0]       dec_q [N_DEC];
  logic [N_RATE-1:0]   rate;

  assign rate[0] = (pre_q == PW'(PRE_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      half_q <= 1'b0;
    end else begin
      pre_q  <= rate[0] ? '0 : pre_q + 1'b1;
      half_q <= ~half_q;
    end
  end

  for (genvar k = 0; k < N_DEC; k++) begin : g_dec
    assign rate[k+1] = rate[k] && (dec_q[k] == DW'(DEC_DIV - 1));
    always_ff @(posedge clk) begin
      if (!rst_n)       dec_q[k] <= '0;
      else if (rate[k]) dec_q[k] <= rate[k+1] ? '0 : dec_q[k] + 1'b1;
    end
  end

  logic [SRC_W-1:0] new_src;
  assign new_src = {enh_mode ? wr_data[7:6] : 2'b00, wr_data[2:0]};

  logic [NCHAN-1:0][SRC_W-1:0] clk_sel, gate_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sel  <= '0;
      gate_sel <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NCHAN; i++) begin
        if (int'(wr_data[5]) == (i / N_CH) % N_UNIT &&
            int'(wr_data[4:3]) == i % N_CH) begin
          if (int'(wr_addr) == CLK_BASE + i / (N_UNIT * N_CH))
            clk_sel[i] <= new_src;
          if (int'(wr_addr) == GATE_BASE + i / (N_UNIT * N_CH))
            gate_sel[i] <= new_src;
        end
      end
    end
  end

  logic [NCHAN-1:0] clk_nx, gate_nx;

  always_comb begin
    for (int i = 0; i < NCHAN; i++) begin
      if (clk_sel[i] == '0)
        clk_nx[i] = ext_clk[i];
      else if (int'(clk_sel[i]) <= N_RATE)
        clk_nx[i] = rate[int'(clk_sel[i]) - 1];
      else if (int'(clk_sel[i]) == FAST_SRC)
        clk_nx[i] = enh_mode & half_q;
      else
        clk_nx[i] = 1'b0;
      gate_nx[i] = (gate_sel[i] == '0) ? 1'b1 :
                   (gate_sel[i] == SRC_W'(1)) ? ext_gate[i] : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_out  <= '0;
      gate_out <= '1;
    end else begin
      clk_out  <= clk_nx;
      gate_out <= gate_nx;
    end
  end
endmodule

module ctr_src_router_chk #(
  parameter int NCHAN    = 18,
  parameter int SRC_W    = 5,
  parameter int N_RATE   = 5,
  parameter int FAST_SRC = 11
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        enh_mode,
  input logic [NCHAN-1:0]            ext_clk,
  input logic [NCHAN-1:0]            ext_gate,
  input logic [NCHAN-1:0][SRC_W-1:0] clk_sel,
  input logic [NCHAN-1:0][SRC_W-1:0] gate_sel,
  input logic [N_RATE-1:0]           rate,
  input logic [NCHAN-1:0]            clk_out,
  input logic [NCHAN-1:0]            gate_out
);
  p_rst_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&gate_out) && (clk_out == '0));

  for (genvar k = 0; k < N_RATE; k++) begin : g_rate
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rate[k] |=> !rate[k]);
  end

  for (genvar i = 0; i < NCHAN; i++) begin : g_ch
    p_clk_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel[i] == '0) |=> (clk_out[i] == $past(ext_clk[i])));
    p_gate_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_sel[i] == '0) |=> gate_out[i]);
    p_gate_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_sel[i] == SRC_W'(1)) |=> (gate_out[i] == $past(ext_gate[i])));
    p_rsv_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(clk_sel[i]) > N_RATE && int'(clk_sel[i]) != FAST_SRC) |=> !clk_out[i]);
    p_rsv_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(gate_sel[i]) > 1) |=> !gate_out[i]);
    p_fast_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(clk_sel[i]) == FAST_SRC && !enh_mode) |=> !clk_out[i]);
  end
endmodule

bind ctr_src_router ctr_src_router_chk #(
  .NCHAN(NCHAN), .SRC_W(SRC_W), .N_RATE(N_RATE), .FAST_SRC(FAST_SRC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode), .ext_clk(ext_clk),
  .ext_gate(ext_gate), .clk_sel(clk_sel), .gate_sel(gate_sel),
  .rate(rate), .clk_out(clk_out), .gate_out(gate_out)
);

// File: tb/ctr_src_router_bench.sv
module ctr_src_router_bench;
  localparam int NCH = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enh_mode = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [NCH-1:0] ext_clk = '0;
  logic [NCH-1:0] ext_gate = '0;
  logic [NCH-1:0] clk_out, gate_out;

  always #10 clk = ~clk;

  ctr_src_router u_ctr_src_router (
    .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ext_clk(ext_clk),
    .ext_gate(ext_gate), .clk_out(clk_out), .gate_out(gate_out)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic mon_clr = 1'b0;
  int last_t [NCH];
  int ivl [NCH];
  int pcnt [NCH];
  bit seen [NCH];
  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      if (mon_clr) begin
        seen[i] = 1'b0; pcnt[i] = 0; ivl[i] = 0;
      end else if (clk_out[i]) begin
        if (seen[i]) ivl[i] = cyc - last_t[i];
        last_t[i] = cyc; seen[i] = 1'b1; pcnt[i] = pcnt[i] + 1;
      end
    end
  end

  // {enh, addr, data, channel (31 = none), gate?, kind: 0 low, 1 high, 2 follows input}
  localparam logic [24:0] VEC [12] = '{
    {1'b0, 8'h1B, 8'h01, 5'd0,  1'b1, 2'd2},
    {1'b0, 8'h1C, 8'h37, 5'd11, 1'b1, 2'd0},
    {1'b0, 8'h18, 8'h2E, 5'd4,  1'b0, 2'd0},
    {1'b0, 8'h1A, 8'h16, 5'd14, 1'b0, 2'd0},
    {1'b0, 8'h1D, 8'hE1, 5'd15, 1'b1, 2'd2},
    {1'b1, 8'h1D, 8'h61, 5'd15, 1'b1, 2'd0},
    {1'b0, 8'h19, 8'h19, 5'd31, 1'b0, 2'd0},
    {1'b0, 8'h1B, 8'h00, 5'd0,  1'b1, 2'd1},
    {1'b1, 8'h19, 8'h88, 5'd7,  1'b0, 2'd0},
    {1'b0, 8'h1A, 8'h36, 5'd17, 1'b0, 2'd0},
    {1'b0, 8'h1A, 8'hB0, 5'd17, 1'b0, 2'd2},
    {1'b0, 8'h1E, 8'h37, 5'd31, 1'b0, 2'd0}
  };

  int clk_k [NCH];
  int gate_k [NCH];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [NCH-1:0] ch, gh, cl, gl;
    ext_clk = '1; ext_gate = '1;
    @(negedge clk); @(negedge clk);
    ch = clk_out; gh = gate_out;
    ext_clk = '0; ext_gate = '0;
    @(negedge clk); @(negedge clk);
    cl = clk_out; gl = gate_out;
    for (int i = 0; i < NCH; i++) begin
      int ec, eg;
      ec = (clk_k[i] == 2) ? 2 : clk_k[i] * 3;
      eg = (gate_k[i] == 2) ? 2 : gate_k[i] * 3;
      check({ch[i], cl[i]} == 2'(ec), req, int'({ch[i], cl[i]}), ec);
      check({gh[i], gl[i]} == 2'(eg), req, int'({gh[i], gl[i]}), eg);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NCH; i++) begin clk_k[i] = 2; gate_k[i] = 1; end
  endtask

  initial begin
    do_reset();
    check(gate_out == '1, "R8 gate high in reset", int'(gate_out), 'h3FFFF);
    check(clk_out == '0, "R8 clock low in reset", int'(clk_out), 0);
    rst_n = 1'b1;
    check_all("R8 R4 defaults");

    for (int v = 0; v < 12; v++) begin
      enh_mode = VEC[v][24];
      host_write(VEC[v][23:16], VEC[v][15:8]);
      if (VEC[v][7:3] != 5'd31) begin
        if (VEC[v][2]) gate_k[VEC[v][7:3]] = int'(VEC[v][1:0]);
        else           clk_k[VEC[v][7:3]]  = int'(VEC[v][1:0]);
      end
      check_all($sformatf("R1 R2 R3 R4 R7 R9 vector %0d", v));
    end
    enh_mode = 1'b0;

    do_reset();
    rst_n = 1'b1;
    check_all("R8 selections cleared");

    enh_mode = 1'b1;
    host_write(8'h18, 8'h01);
    host_write(8'h18, 8'h0A);
    host_write(8'h18, 8'h13);
    host_write(8'h18, 8'h24);
    host_write(8'h18, 8'h2D);
    host_write(8'h18, 8'h73);
    @(negedge clk); mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;
    repeat (90000) @(negedge clk);
    check(ivl[0] == 4,     "R5 10 MHz period",  ivl[0], 4);
    check(ivl[1] == 40,    "R5 1 MHz period",   ivl[1], 40);
    check(ivl[2] == 400,   "R5 100 kHz period", ivl[2], 400);
    check(ivl[3] == 4000,  "R5 10 kHz period",  ivl[3], 4000);
    check(ivl[4] == 40000, "R5 1 kHz period",   ivl[4], 40000);
    check(ivl[5] == 2,     "R6 20 MHz period",  ivl[5], 2);
    check(pcnt[0] > 20000, "R5 single-cycle pulses", pcnt[0], 22500);

    enh_mode = 1'b0;
    @(negedge clk); @(negedge clk);
    mon_clr = 1'b1; @(negedge clk); mon_clr = 1'b0;
    repeat (100) @(negedge clk);
    check(pcnt[5] == 0, "R6 20 MHz off in normal mode", pcnt[5], 0);
    check(pcnt[0] == 25, "R5 10 MHz unaffected by mode", pcnt[0], 25);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule